// File: doc/BRIEF.md
# Frame-Locked Clock Prescaler

This block turns a master clock of unknown rate into two clock enables of fixed rate: a 256 kHz enable for the internal converter logic and an 8 kHz sample enable. It does not need to be told the master rate. It counts master clock cycles between rising edges of the frame sync, which arrives at 8 kHz. It matches that count to one of seven supported master rates (256, 512, 1536, 1544, 2048, 2560 and 4096 kHz). A phase accumulator then spreads 32 enable pulses evenly over each frame period. This covers the fractional ratio of the 1544 kHz case without a separate divider.

The block also sequences power. It drops into standby when the power-up input is low, or when the frame sync has been absent for longer than the longest supported frame. It leaves standby on the first frame sync edge seen while the power-up input is high. After that it holds back the transmit permit until two more frame edges have arrived, so that a serial driver cannot collide on a shared bus. The frame sync and the power-up input are assumed to be synchronous to the master clock.

Top module: `frame_prescaler`

## Requirements
- R1: While reset is held and right after it is released, `standby` is 1 and `locked`, `tx_permit`, `tick_256` and `tick_8k` are 0.
- R2: The master-cycle count between two consecutive frame-sync rising edges is classified against the nominal periods 32, 64, 192, 193, 256, 320 and 512 with a tolerance of ±2 cycles. When two classes are within tolerance, the nearer one wins. A tie goes to the smaller period, so counts 190..192 select 192 and counts 193..195 select 193.
- R3: The active ratio changes only when two consecutive measured frames fall in the same class, and `locked` rises at that edge. A frame whose class equals the active ratio keeps or sets `locked`.
- R4: A measured count that lies outside every tolerance window clears `locked` at that edge. The active ratio is kept, so `tick_256` keeps its previous rate.
- R5: Outside standby, once a ratio with nominal period P is active, any P consecutive master cycles contain exactly 32 `tick_256` pulses.
- R6: `tick_8k` pulses once for every 32 `tick_256` pulses, and only in a cycle where `tick_256` is also high, so any P-cycle window holds exactly one.
- R7: With the power-up input high and no frame-sync rising edge for 515 master cycles (longest period plus tolerance plus one), `standby` becomes 1.
- R8: When `pwr_up` is 0, `standby` is 1 from the next clock on.
- R9: Standby ends on the first frame-sync rising edge while `pwr_up` is 1. The ratio is then cleared, so the block relocks only after two matching frames.
- R10: `tx_permit` is 0 in standby and after waking. It rises in the cycle after the second frame-sync rising edge that follows the waking edge.
- R11: Once standby has lasted a full cycle, `tick_256`, `tick_8k` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | 8 kHz frame sync, sampled on the master clock |
| pwr_up | input | 1 | Power-up request; low forces standby |
| tick_256 | output | 1 | One-cycle 256 kHz clock enable |
| tick_8k | output | 1 | One-cycle 8 kHz sample enable |
| standby | output | 1 | Low-power state flag |
| locked | output | 1 | Last measured frame matched the active ratio |
| tx_permit | output | 1 | Serial transmit may drive the bus |

## Verification
The bench builds the block with its default parameters: 32 enables per frame, a ±2 tolerance, a 10-bit frame counter and a two-frame wake delay. At these values every one of the seven nominal periods can be locked and its tick density measured over a full frame within a few thousand cycles. The 515-cycle absence limit, the tolerance edges at ±2 and ±3, and the 192/193 tie region also become reachable with short directed frame sequences.

// File: rtl/prescaler_pkg.sv
// Package: shared constants for the frame-locked prescaler.
// Holds the nominal master-cycle counts per 8 kHz frame for every supported
// master rate, ordered by increasing period (the order sets tie priority).
package prescaler_pkg;

    localparam int unsigned NUM_RATES = 7;
    localparam int unsigned IDX_W     = $clog2(NUM_RATES);

    // Master cycles per frame: 256, 512, 1536, 1544, 2048, 2560, 4096 kHz.
    localparam int unsigned PERIODS [NUM_RATES] = '{32, 64, 192, 193, 256, 320, 512};

    // Longest nominal period, used for the frame-absence limit.
    function automatic int unsigned max_period();
        int unsigned m;
        m = 0;
        for (int i = 0; i < int'(NUM_RATES); i++) begin
            if (PERIODS[i] > m) m = PERIODS[i];
        end
        return m;
    endfunction

    // Nominal period of a class index; out-of-range indices give 0.
    function automatic int unsigned period_of(logic [IDX_W-1:0] idx);
        int unsigned p;
        p = 0;
        for (int i = 0; i < int'(NUM_RATES); i++) begin
            if (int'(idx) == i) p = PERIODS[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/fsync_meter.sv
// Module: fsync_meter
// Detects frame-sync rising edges, counts master cycles between them and
// classifies the count to the nearest supported period within TOL cycles.
// Assumes fsync is synchronous to clk.
module fsync_meter
    import prescaler_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned TOL   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             fs_rise,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             cls_hit,
    output logic [IDX_W-1:0] cls_idx
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic fs_q;

    // Previous frame-sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fsync;
    end

    assign fs_rise = fsync & ~fs_q;

    // Cycle counter: restarts at 1 on each edge, saturates at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                    frame_cnt <= '0;
        else if (fs_rise)              frame_cnt <= CNT_W'(1);
        else if (frame_cnt != CNT_MAX) frame_cnt <= frame_cnt + CNT_W'(1);
    end

    // Nearest-period classification; strict compare keeps the lower index on a tie.
    always_comb begin
        int best;
        int diff;
        cls_hit = 1'b0;
        cls_idx = '0;
        best    = int'(TOL) + 1;
        for (int i = 0; i < int'(NUM_RATES); i++) begin
            diff = int'(frame_cnt) - int'(PERIODS[i]);
            if (diff < 0) diff = -diff;
            if (diff < best) begin
                best    = diff;
                cls_hit = 1'b1;
                cls_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ratio_lock.sv
// Module: ratio_lock
// Holds the active divide ratio and the lock flag. A new ratio is adopted
// only when two consecutive measured frames give the same class; a frame
// outside every window drops lock but keeps the ratio. Standby clears all.
module ratio_lock
    import prescaler_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             meas_valid,
    input  logic             cls_hit,
    input  logic [IDX_W-1:0] cls_idx,
    output logic [IDX_W-1:0] ratio_idx,
    output logic             have_ratio,
    output logic             locked,
    output logic             ratio_upd
);

    logic [IDX_W-1:0] cand_idx;
    logic             cand_vld;

    // Adopt a new ratio on a repeated class that differs from the active one.
    assign ratio_upd = meas_valid && !standby && cls_hit && cand_vld &&
                       (cls_idx == cand_idx) &&
                       (!have_ratio || (cls_idx != ratio_idx));

    // Candidate, active ratio and lock state update on measured edges.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            ratio_idx  <= '0;
            have_ratio <= 1'b0;
            locked     <= 1'b0;
            cand_idx   <= '0;
            cand_vld   <= 1'b0;
        end else if (meas_valid) begin
            if (!cls_hit) begin
                locked   <= 1'b0;
                cand_vld <= 1'b0;
            end else begin
                if (ratio_upd) begin
                    ratio_idx  <= cls_idx;
                    have_ratio <= 1'b1;
                    locked     <= 1'b1;
                end else begin
                    locked <= have_ratio && (cls_idx == ratio_idx);
                end
                cand_idx <= cls_idx;
                cand_vld <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/enable_gen.sv
// Module: enable_gen
// Phase accumulator that spreads FRAME_TICKS pulses evenly over `period`
// master cycles, plus a modulo-FRAME_TICKS sub-count for the sample enable.
// Assumes FRAME_TICKS is a power of two and period >= FRAME_TICKS.
module enable_gen #(
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned FRAME_TICKS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] period,
    output logic             tick_fast,
    output logic             tick_slow
);

    localparam int unsigned SUB_W = $clog2(FRAME_TICKS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(FRAME_TICKS - 1);

    logic [CNT_W-1:0] acc;
    logic [CNT_W:0]   sum;
    logic [SUB_W-1:0] sub;

    assign sum = {1'b0, acc} + (CNT_W+1)'(FRAME_TICKS);

    // Accumulate FRAME_TICKS per cycle; wrap by `period` and emit a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clear) begin
            acc       <= '0;
            sub       <= '0;
            tick_fast <= 1'b0;
            tick_slow <= 1'b0;
        end else if (sum >= {1'b0, period}) begin
            acc       <= CNT_W'(sum - {1'b0, period});
            tick_fast <= 1'b1;
            tick_slow <= (sub == SUB_LAST);
            sub       <= sub + SUB_W'(1);
        end else begin
            acc       <= sum[CNT_W-1:0];
            tick_fast <= 1'b0;
            tick_slow <= 1'b0;
        end
    end

endmodule

// File: rtl/power_seq.sv
// Module: power_seq
// Standby and wake sequencing. Enters standby on a low power-up input or
// when no frame edge arrives for ABSENT_CYCLES; leaves it on a frame edge
// with power-up high, then permits transmit after WAKE_FRAMES more edges.
module power_seq #(
    parameter int unsigned CNT_W         = 10,
    parameter int unsigned ABSENT_CYCLES = 515,
    parameter int unsigned WAKE_FRAMES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_up,
    input  logic             fs_rise,
    input  logic [CNT_W-1:0] frame_cnt,
    output logic             standby,
    output logic             tx_permit
);

    localparam int unsigned WF_W = $clog2(WAKE_FRAMES + 1);
    localparam logic [WF_W-1:0] WF_DONE = WF_W'(WAKE_FRAMES);
    localparam logic [WF_W-1:0] WF_LAST = WF_W'(WAKE_FRAMES - 1);

    logic [WF_W-1:0] wake_cnt;
    logic            absent;

    assign absent = !fs_rise && (int'(frame_cnt) >= int'(ABSENT_CYCLES));

    // Standby state, wake frame count and transmit permit.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_up) begin
            standby   <= 1'b1;
            tx_permit <= 1'b0;
            wake_cnt  <= '0;
        end else if (standby) begin
            if (fs_rise) standby <= 1'b0;
            tx_permit <= 1'b0;
            wake_cnt  <= '0;
        end else if (absent) begin
            standby   <= 1'b1;
            tx_permit <= 1'b0;
            wake_cnt  <= '0;
        end else if (fs_rise && (wake_cnt != WF_DONE)) begin
            if (wake_cnt == WF_LAST) tx_permit <= 1'b1;
            wake_cnt <= wake_cnt + WF_W'(1);
        end
    end

endmodule

// File: rtl/frame_prescaler.sv
// Module: frame_prescaler (top)
// Measures the master clock against the 8 kHz frame sync, picks the divide
// ratio, produces the 256 kHz and 8 kHz enables, and sequences standby and
// transmit permit. All inputs are synchronous to clk.
module frame_prescaler
    import prescaler_pkg::*;
#(
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned FRAME_TICKS = 32,
    parameter int unsigned TOL         = 2,
    parameter int unsigned WAKE_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic pwr_up,
    output logic tick_256,
    output logic tick_8k,
    output logic standby,
    output logic locked,
    output logic tx_permit
);

    localparam int unsigned ABSENT_CYCLES = max_period() + TOL + 1;

    logic             fs_rise;
    logic [CNT_W-1:0] frame_cnt;
    logic             cls_hit;
    logic [IDX_W-1:0] cls_idx;
    logic [IDX_W-1:0] ratio_idx;
    logic             have_ratio;
    logic             ratio_upd;
    logic [CNT_W-1:0] period;

    fsync_meter #(.CNT_W(CNT_W), .TOL(TOL)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .fs_rise   (fs_rise),
        .frame_cnt (frame_cnt),
        .cls_hit   (cls_hit),
        .cls_idx   (cls_idx)
    );

    ratio_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .meas_valid (fs_rise),
        .cls_hit    (cls_hit),
        .cls_idx    (cls_idx),
        .ratio_idx  (ratio_idx),
        .have_ratio (have_ratio),
        .locked     (locked),
        .ratio_upd  (ratio_upd)
    );

    assign period = CNT_W'(period_of(ratio_idx));

    enable_gen #(.CNT_W(CNT_W), .FRAME_TICKS(FRAME_TICKS)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (have_ratio && !standby),
        .clear     (ratio_upd),
        .period    (period),
        .tick_fast (tick_256),
        .tick_slow (tick_8k)
    );

    power_seq #(
        .CNT_W         (CNT_W),
        .ABSENT_CYCLES (ABSENT_CYCLES),
        .WAKE_FRAMES   (WAKE_FRAMES)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_up    (pwr_up),
        .fs_rise   (fs_rise),
        .frame_cnt (frame_cnt),
        .standby   (standby),
        .tx_permit (tx_permit)
    );

endmodule

// File: rtl/prescaler_chk.sv
// Module: prescaler_chk
// Port-level checker for frame_prescaler, attached with bind below.
// Keeps its own count of cycles since the last frame edge.
module prescaler_chk #(
    parameter int unsigned CNT_W         = 10,
    parameter int unsigned ABSENT_CYCLES = 515
) (
    input logic clk,
    input logic rst_n,
    input logic fsync,
    input logic pwr_up,
    input logic tick_256,
    input logic tick_8k,
    input logic standby,
    input logic locked,
    input logic tx_permit
);

    logic             fs_d;
    logic [CNT_W-1:0] gap;

    // Independent cycles-since-edge counter for the absence window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_d <= 1'b0;
            gap  <= '0;
        end else begin
            fs_d <= fsync;
            if (fsync && !fs_d)  gap <= CNT_W'(1);
            else if (gap != '1)  gap <= gap + CNT_W'(1);
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (standby && !locked && !tx_permit && !tick_256 && !tick_8k));

    // R6
    slow_in_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_8k |-> tick_256);

    // R3
    lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(fsync));

    // R7
    absent_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gap) > int'(ABSENT_CYCLES)) |-> standby);

    // R8
    pwr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> standby);

    // R10
    permit_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_permit |-> !standby);

    // R10
    permit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_permit) |-> $past(fsync));

    // R11
    stby_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && $past(standby)) |-> (!tick_256 && !tick_8k && !locked));

endmodule

bind frame_prescaler prescaler_chk #(
    .CNT_W         (CNT_W),
    .ABSENT_CYCLES (ABSENT_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .pwr_up    (pwr_up),
    .tick_256  (tick_256),
    .tick_8k   (tick_8k),
    .standby   (standby),
    .locked    (locked),
    .tx_permit (tx_permit)
);

// File: tb/sim_frame_prescaler.sv
`timescale 1ns/1ps
module sim_frame_prescaler;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic pwr_up = 1'b0;
    logic tick_256, tick_8k, standby, locked, tx_permit;

    int n_run = 0;
    int n_fail = 0;
    int n_fast = 0;
    int n_slow = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    frame_prescaler u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .pwr_up    (pwr_up),
        .tick_256  (tick_256),
        .tick_8k   (tick_8k),
        .standby   (standby),
        .locked    (locked),
        .tx_permit (tx_permit)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One frame: a one-cycle fsync pulse then idle, len cycles edge to edge.
    task automatic frame(input int len, input bit count);
        fsync = 1'b1;
        n_fast = 0;
        n_slow = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) fsync = 1'b0;
            if (count && tick_256) n_fast++;
            if (count && tick_8k)  n_slow++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic test_reset();
        repeat (4) @(negedge clk);
        check("R1 standby", int'(standby), 1);
        check("R1 locked", int'(locked), 0);
        check("R1 tx_permit", int'(tx_permit), 0);
        check("R1 ticks", int'(tick_256) + int'(tick_8k), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(standby) + 2*int'(locked), 1);
        pwr_up = 1'b1;
    endtask

    // Lock to period p and measure one frame of tick density (R3, R5, R6).
    task automatic lock_rate(input int p);
        frame(p, 1'b0);
        frame(p, 1'b0);
        check($sformatf("R3 no lock after one frame p=%0d", p), int'(locked), 0);
        frame(p, 1'b0);
        check($sformatf("R3 locked p=%0d", p), int'(locked), 1);
        check($sformatf("R10 permit p=%0d", p), int'(tx_permit), 1);
        frame(p, 1'b1);
        check($sformatf("R5 fast ticks p=%0d", p), n_fast, 32);
        check($sformatf("R6 slow ticks p=%0d", p), n_slow, 1);
    endtask

    task automatic test_off_rate();
        frame(100, 1'b0);
        frame(512, 1'b1);
        check("R4 lock dropped", int'(locked), 0);
        check("R4 ratio held fast ticks", n_fast, 32);
        frame(512, 1'b0);
        check("R3 relock same class", int'(locked), 1);
    endtask

    task automatic test_tolerance();
        frame(514, 1'b0);
        frame(510, 1'b0);
        check("R2 +2 inside", int'(locked), 1);
        frame(509, 1'b0);
        check("R2 -2 inside", int'(locked), 1);
        frame(512, 1'b0);
        check("R2 -3 outside", int'(locked), 0);
        frame(512, 1'b0);
        check("R2 back inside", int'(locked), 1);
    endtask

    task automatic test_nearest();
        frame(191, 1'b0);
        frame(191, 1'b0);
        frame(191, 1'b0);
        check("R2 191 locks", int'(locked), 1);
        frame(192, 1'b1);
        check("R2 191 maps to 192", n_fast, 32);
        frame(194, 1'b0);
        frame(194, 1'b0);
        check("R2 194 is new class", int'(locked), 0);
        frame(194, 1'b0);
        frame(193, 1'b1);
        check("R2 194 maps to 193", n_fast, 32);
        check("R2 194 locked", int'(locked), 1);
    endtask

    task automatic test_absent();
        frame(1, 1'b0);
        idle(510);
        check("R7 not yet standby", int'(standby), 0);
        idle(10);
        check("R7 standby after absence", int'(standby), 1);
        check("R10 permit off in standby", int'(tx_permit), 0);
        n_fast = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (tick_256) n_fast++;
        end
        check("R11 no ticks in standby", n_fast, 0);
        check("R11 no lock in standby", int'(locked), 0);
    endtask

    task automatic test_wake_and_pwr();
        frame(64, 1'b0);
        check("R9 woke on edge", int'(standby), 0);
        check("R10 permit held frame 0", int'(tx_permit), 0);
        frame(64, 1'b0);
        check("R10 permit held frame 1", int'(tx_permit), 0);
        check("R9 ratio cleared", int'(locked), 0);
        frame(64, 1'b0);
        check("R10 permit after two frames", int'(tx_permit), 1);
        check("R9 relocked", int'(locked), 1);
        pwr_up = 1'b0;
        @(negedge clk);
        check("R8 standby on pwr low", int'(standby), 1);
        check("R8 permit dropped", int'(tx_permit), 0);
        frame(64, 1'b1);
        frame(64, 1'b1);
        check("R8 stays down with frames", int'(standby), 1);
        check("R11 no ticks while down", n_fast, 0);
        pwr_up = 1'b1;
        frame(64, 1'b0);
        check("R9 wake after pwr high", int'(standby), 0);
        frame(64, 1'b0);
        check("R10 held after re-wake", int'(tx_permit), 0);
        frame(64, 1'b0);
        check("R10 permit after re-wake", int'(tx_permit), 1);
    endtask

    initial begin
        test_reset();
        lock_rate(32);
        lock_rate(64);
        lock_rate(192);
        lock_rate(193);
        lock_rate(256);
        lock_rate(320);
        lock_rate(512);
        test_off_rate();
        test_tolerance();
        test_nearest();
        test_absent();
        test_wake_and_pwr();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule